// File: doc/BRIEF.md
# Interrupt PSW Swap Sequencer

This block takes interruption requests from six classes, picks one of them, and switches the processor to that class's handler. It does this with a status-word exchange over a single memory request port. When it accepts a request, it captures a snapshot of the running program's state. The snapshot holds the control part of the program status word (PSW), the resume address and an instruction-length code. The block then performs three transfers in a fixed order. It writes the snapshot to the class's save slot. It writes the class's cause code to the class's code slot. Last, it reads the class's handler PSW and presents it as the new current PSW.

The surrounding CPU uses the block as follows. It raises one request line per class and holds the matching cause code on that class's lane. It supplies its run state, the address of the next instruction, the length of the last instruction and a flag that marks a program condition that must re-execute the faulting instruction. The block returns a one-cycle acknowledge for the class it took, a busy flag, and a one-cycle load strobe that carries the new PSW. When a restart is taken while the CPU is stopped, the block also gives a strobe that tells the CPU to enter the operating state.

Top module: `irq_swap_seq`

## Requirements
- R1: Request bits are mapped to classes as follows: bit 0 machine check, bit 1 program, bit 2 supervisor call, bit 3 external, bit 4 I/O, bit 5 restart. When more than one eligible bit is set, the lowest index wins. The accepted class is shown on `ack_o` as a one-hot pulse lasting one cycle, in the cycle after the clock edge that accepted it.
- R2: While `run_i` is 0, only the restart bit is eligible. Any other pending request is ignored: no acknowledge is given, `busy_o` stays low and no memory transfer starts.
- R3: A swap makes exactly three transfers, in this order: a write of the old PSW, a write of the cause code, then a read of the new PSW. Each transfer completes on a cycle where `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, the address, the direction and the write data hold steady.
- R4: The slot addresses for class index k are: old PSW at 0x020 + 8k, new PSW at 0x060 + 8k, cause code at 0x0A0 + 8k.
- R5: The old PSW word is {control[63:26], ILC[25:24], address[23:0]}. For every class except the re-execution case in R7, the address field equals `ia_i`.
- R6: The ILC field equals `ilen_i` (a length in halfwords, from 1 to 3) for the program and supervisor-call classes, and 0 for all other classes.
- R7: For a program interruption with `refetch_i` set, the address field is `ia_i` minus twice `ilen_i`, taken modulo 2^24.
- R8: The cause word is the class's 16-bit lane `cause_i[16k+15:16k]`, zero-extended to 64 bits.
- R9: In the cycle after the read completes, `psw_load_o` pulses for one cycle, `psw_o` holds the data that was read, and `busy_o` is low.
- R10: `busy_o` is high from the cycle after acceptance until the load cycle. No other request is accepted while it is high.
- R11: `go_run_o` pulses together with `psw_load_o` exactly when the swap was for a restart accepted with `run_i` at 0. Otherwise it stays 0.
- R12: All class-dependent inputs are captured at acceptance. Changing them during a swap does not alter that swap's transfers.
- R13: After reset, `busy_o`, `ack_o`, `mem_valid_o`, `psw_load_o`, `go_run_o` and `psw_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Pending request per class |
| cause_i | input | 96 | Cause code per class, 16 bits per lane |
| run_i | input | 1 | CPU is in the operating state |
| ctl_i | input | 38 | Control part of the current PSW |
| ia_i | input | 24 | Address of the next instruction |
| ilen_i | input | 2 | Length of the last instruction, in halfwords |
| refetch_i | input | 1 | Program condition re-executes the faulting instruction |
| ack_o | output | 6 | One-hot acknowledge of the accepted class |
| busy_o | output | 1 | Swap in progress |
| mem_valid_o | output | 1 | Memory request valid |
| mem_write_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 12 | Memory slot address |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Memory accepts or completes the request |
| mem_rdata_i | input | 64 | Read data, valid together with ready |
| psw_o | output | 64 | Last loaded new PSW |
| psw_load_o | output | 1 | New PSW load strobe |
| go_run_o | output | 1 | Request to enter the operating state |

## Verification
The bench leaves all six classes pending and lets them drain back to back. A design with a wrong priority order, or one that loses the remaining requests, would show up here as an acknowledge out of sequence. A stopped CPU is given every class except restart, and then the same set plus restart. A design that ignored the run state would start a swap in the first case. One that failed to start the CPU would leave the restart strobe low in the second. A program re-execution case whose address goes below zero checks the wrap of the address. A design that backed off by halfwords instead of bytes, or that also backed off for supervisor calls, would store the wrong address. Random memory stalls, together with inputs changed right after the acknowledge, catch a design that drops a request during a stall or that keeps reading live inputs after it has accepted.

// File: rtl/irq_swap_pkg.sv
package irq_swap_pkg;
  localparam int NCLS     = 6;
  localparam int IDXW     = 3;
  localparam int CLS_MCHK = 0;
  localparam int CLS_PGM  = 1;
  localparam int CLS_SVC  = 2;
  localparam int CLS_EXT  = 3;
  localparam int CLS_IO   = 4;
  localparam int CLS_RST  = 5;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_OLD,
    SQ_CODE,
    SQ_NEW
  } sq_state_e;
endpackage

// File: rtl/irq_class_pick.sv
module irq_class_pick #(
  parameter int NCLS    = 6,
  parameter int IDXW    = 3,
  parameter int RST_IDX = 5
) (
  input  logic [NCLS-1:0] req,
  input  logic            run,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output logic [NCLS-1:0] grant
);
  logic [NCLS-1:0] elig;
  logic [NCLS-1:0] rst_mask;

  assign rst_mask = NCLS'(1) << RST_IDX;

  always_comb begin
    elig = run ? req : (req & rst_mask);
    hit  = 1'b0;
    idx  = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
    grant = hit ? (NCLS'(1) << idx) : '0;
  end
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
  parameter int NCLS      = 6,
  parameter int IDXW      = 3,
  parameter int MAW       = 12,
  parameter int OLD_BASE  = 32,
  parameter int NEW_BASE  = 96,
  parameter int CODE_BASE = 160,
  parameter int STRIDE    = 8
) (
  input  logic [IDXW-1:0] idx,
  output logic [MAW-1:0]  old_addr,
  output logic [MAW-1:0]  new_addr,
  output logic [MAW-1:0]  code_addr
);
  logic [MAW-1:0] old_tab  [NCLS];
  logic [MAW-1:0] new_tab  [NCLS];
  logic [MAW-1:0] code_tab [NCLS];

  for (genvar g = 0; g < NCLS; g++) begin : g_slot
    assign old_tab[g]  = MAW'(OLD_BASE + g * STRIDE);
    assign new_tab[g]  = MAW'(NEW_BASE + g * STRIDE);
    assign code_tab[g] = MAW'(CODE_BASE + g * STRIDE);
  end

  always_comb begin
    old_addr  = old_tab[0];
    new_addr  = new_tab[0];
    code_addr = code_tab[0];
    for (int i = 0; i < NCLS; i++) begin
      if (idx == IDXW'(i)) begin
        old_addr  = old_tab[i];
        new_addr  = new_tab[i];
        code_addr = code_tab[i];
      end
    end
  end
endmodule

// File: rtl/irq_old_psw_fmt.sv
module irq_old_psw_fmt #(
  parameter int CTLW    = 38,
  parameter int AW      = 24,
  parameter int IDXW    = 3,
  parameter int PGM_IDX = 1,
  parameter int SVC_IDX = 2
) (
  input  logic [CTLW-1:0]      ctl,
  input  logic [AW-1:0]        ia,
  input  logic [1:0]           ilen,
  input  logic                 refetch,
  input  logic [IDXW-1:0]      idx,
  output logic [CTLW+2+AW-1:0] word
);
  logic           is_pgm;
  logic           is_svc;
  logic [1:0]     ilc;
  logic [AW-1:0]  back_bytes;
  logic [AW-1:0]  addr;

  assign is_pgm     = (idx == IDXW'(PGM_IDX));
  assign is_svc     = (idx == IDXW'(SVC_IDX));
  assign ilc        = (is_pgm || is_svc) ? ilen : 2'b00;
  assign back_bytes = AW'({ilen, 1'b0});
  assign addr       = (is_pgm && refetch) ? (ia - back_bytes) : ia;
  assign word       = {ctl, ilc, addr};
endmodule

// File: rtl/irq_swap_seq.sv
module irq_swap_seq
  import irq_swap_pkg::*;
#(
  parameter int CW        = 16,
  parameter int AW        = 24,
  parameter int CTLW      = 38,
  parameter int MAW       = 12,
  parameter int OLD_BASE  = 32,
  parameter int NEW_BASE  = 96,
  parameter int CODE_BASE = 160,
  parameter int STRIDE    = 8,
  localparam int DW       = CTLW + 2 + AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCLS-1:0]    req_i,
  input  logic [NCLS*CW-1:0] cause_i,
  input  logic               run_i,
  input  logic [CTLW-1:0]    ctl_i,
  input  logic [AW-1:0]      ia_i,
  input  logic [1:0]         ilen_i,
  input  logic               refetch_i,
  output logic [NCLS-1:0]    ack_o,
  output logic               busy_o,
  output logic               mem_valid_o,
  output logic               mem_write_o,
  output logic [MAW-1:0]     mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [DW-1:0]      psw_o,
  output logic               psw_load_o,
  output logic               go_run_o
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // class selection
  logic            pick_hit;
  logic [IDXW-1:0] pick_idx;
  logic [NCLS-1:0] pick_grant;

  irq_class_pick #(.NCLS(NCLS), .IDXW(IDXW), .RST_IDX(CLS_RST)) u_pick (
    .req   (req_i),
    .run   (run_i),
    .hit   (pick_hit),
    .idx   (pick_idx),
    .grant (pick_grant)
  );

  // old PSW image built from live inputs, captured on accept
  logic [DW-1:0] old_img;

  irq_old_psw_fmt #(
    .CTLW(CTLW), .AW(AW), .IDXW(IDXW), .PGM_IDX(CLS_PGM), .SVC_IDX(CLS_SVC)
  ) u_fmt (
    .ctl     (ctl_i),
    .ia      (ia_i),
    .ilen    (ilen_i),
    .refetch (refetch_i),
    .idx     (pick_idx),
    .word    (old_img)
  );

  // state
  sq_state_e       state_q, state_d;
  logic [IDXW-1:0] cls_q;
  logic [CW-1:0]   cause_q;
  logic [DW-1:0]   old_q;
  logic            wake_q;
  logic [NCLS-1:0] ack_q, ack_d;
  logic            load_q, load_d;
  logic            go_q, go_d;
  logic [DW-1:0]   psw_q;
  logic            cap_en;
  logic            fin_en;

  // slot addresses of the captured class
  logic [MAW-1:0] old_addr, new_addr, code_addr;

  irq_slot_map #(
    .NCLS(NCLS), .IDXW(IDXW), .MAW(MAW), .OLD_BASE(OLD_BASE),
    .NEW_BASE(NEW_BASE), .CODE_BASE(CODE_BASE), .STRIDE(STRIDE)
  ) u_map (
    .idx       (cls_q),
    .old_addr  (old_addr),
    .new_addr  (new_addr),
    .code_addr (code_addr)
  );

  assign cap_en = (state_q == SQ_IDLE) && pick_hit;
  assign fin_en = (state_q == SQ_NEW) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    ack_d   = '0;
    load_d  = 1'b0;
    go_d    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (pick_hit) begin
          state_d = SQ_OLD;
          ack_d   = pick_grant;
        end
      end
      SQ_OLD:  if (mem_ready_i) state_d = SQ_CODE;
      SQ_CODE: if (mem_ready_i) state_d = SQ_NEW;
      SQ_NEW: begin
        if (mem_ready_i) begin
          state_d = SQ_IDLE;
          load_d  = 1'b1;
          go_d    = wake_q;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      ack_q   <= '0;
      load_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      load_q  <= load_d;
      go_q    <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q   <= '0;
      cause_q <= '0;
      old_q   <= '0;
      wake_q  <= 1'b0;
    end else if (cap_en) begin
      cls_q   <= pick_idx;
      cause_q <= cause_i[pick_idx*CW +: CW];
      old_q   <= old_img;
      wake_q  <= (pick_idx == IDXW'(CLS_RST)) && !run_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     psw_q <= '0;
    else if (fin_en) psw_q <= mem_rdata_i;
  end

  // memory port
  always_comb begin
    mem_valid_o = 1'b0;
    mem_write_o = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      SQ_OLD: begin
        mem_valid_o = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = old_addr;
        mem_wdata_o = old_q;
      end
      SQ_CODE: begin
        mem_valid_o = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = code_addr;
        mem_wdata_o = {{(DW-CW){1'b0}}, cause_q};
      end
      SQ_NEW: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = new_addr;
      end
      default: ;
    endcase
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign ack_o      = ack_q;
  assign psw_load_o = load_q;
  assign go_run_o   = go_q;
  assign psw_o      = psw_q;

  // checks
  a_r1_ack_onehot: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(ack_o));

  a_r2_stopped_only_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ack_o != '0) && !$past(run_i)) |-> ack_o[CLS_RST]);

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o)));

  a_r9_load_after_read: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i && !mem_write_o) |=> (psw_load_o && !busy_o
      && (psw_o == $past(mem_rdata_i))));

  a_r9_load_single: assert property (@(posedge clk) disable iff (!rst_ni)
    psw_load_o |=> !psw_load_o);

  a_r10_valid_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_valid_o |-> busy_o);

  a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |=> ((ack_o == '0) || $rose(busy_o)));

  a_r11_go_with_load: assert property (@(posedge clk) disable iff (!rst_ni)
    go_run_o |-> psw_load_o);
endmodule

// File: tb/irq_swap_seq_test.sv
`timescale 1ns/1ps
module irq_swap_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  req_i;
  logic [95:0] cause_i;
  logic        run_i;
  logic [37:0] ctl_i;
  logic [23:0] ia_i;
  logic [1:0]  ilen_i;
  logic        refetch_i;
  logic [5:0]  ack_o;
  logic        busy_o;
  logic        mem_valid_o;
  logic        mem_write_o;
  logic [11:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic        mem_ready_i;
  logic [63:0] mem_rdata_i;
  logic [63:0] psw_o;
  logic        psw_load_o;
  logic        go_run_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_swap_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cause_i(cause_i), .run_i(run_i),
    .ctl_i(ctl_i), .ia_i(ia_i), .ilen_i(ilen_i), .refetch_i(refetch_i),
    .ack_o(ack_o), .busy_o(busy_o), .mem_valid_o(mem_valid_o),
    .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i), .psw_o(psw_o),
    .psw_load_o(psw_load_o), .go_run_o(go_run_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_pick(input logic [5:0] r, input bit run);
    logic [5:0] e;
    e = run ? r : (r & 6'b100000);
    for (int i = 0; i < 6; i++) if (e[i]) return i;
    return -1;
  endfunction

  function automatic logic [63:0] exp_old(input int k, input logic [37:0] c,
      input logic [23:0] a, input logic [1:0] l, input bit rf);
    logic [1:0]  ilc;
    logic [23:0] ad;
    ilc = (k == 1 || k == 2) ? l : 2'b00;
    ad  = (k == 1 && rf) ? (a - {21'b0, l, 1'b0}) : a;
    return {c, ilc, ad};
  endfunction

  function automatic logic [11:0] slot_old(input int k);  return 12'(32 + 8*k);  endfunction
  function automatic logic [11:0] slot_new(input int k);  return 12'(96 + 8*k);  endfunction
  function automatic logic [11:0] slot_code(input int k); return 12'(160 + 8*k); endfunction
  function automatic logic [63:0] mkword(input logic [11:0] a);
    return {a, 20'hABCDE, a, 20'h13579};
  endfunction

  task automatic scramble();
    ia_i      = 24'($urandom);
    ctl_i     = 38'({$urandom, $urandom});
    cause_i   = {$urandom, $urandom, $urandom};
    ilen_i    = 2'(1 + $urandom % 3);
    refetch_i = 1'($urandom);
  endtask

  task automatic service(input int k, input bit keep, input bit exp_go,
                         input logic [63:0] e_old, input logic [63:0] e_code,
                         input bit always_ready);
    int n = 0;
    int guard = 0;
    bit seen_ack = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 300) begin
        chk(1'b0, "R10 swap did not finish", 64'(n), 64'd3);
        break;
      end
      if (ack_o != 6'b0) begin
        chk(ack_o == (6'b1 << k), "R1 acknowledge", 64'(ack_o), 64'(6'b1 << k));
        seen_ack = 1;
        if (keep) req_i = req_i & ~ack_o;
        else begin
          req_i = 6'b0;
          scramble();   // R12: late changes must not reach this swap
        end
      end
      if (mem_valid_o) chk(busy_o, "R10 busy during transfer", 64'(busy_o), 64'd1);
      mem_ready_i = always_ready ? 1'b1 : (($urandom % 3) != 0);
      mem_rdata_i = mkword(mem_addr_o);
      if (mem_valid_o && mem_ready_i) begin
        case (n)
          0: begin
            chk(mem_write_o && mem_addr_o == slot_old(k), "R3 R4 old slot write",
                64'({mem_write_o, mem_addr_o}), 64'({1'b1, slot_old(k)}));
            chk(mem_wdata_o == e_old, "R5 R6 R7 R12 old PSW", mem_wdata_o, e_old);
          end
          1: begin
            chk(mem_write_o && mem_addr_o == slot_code(k), "R3 R4 code slot write",
                64'({mem_write_o, mem_addr_o}), 64'({1'b1, slot_code(k)}));
            chk(mem_wdata_o == e_code, "R8 cause word", mem_wdata_o, e_code);
          end
          2: chk(!mem_write_o && mem_addr_o == slot_new(k), "R3 R4 new slot read",
                 64'({mem_write_o, mem_addr_o}), 64'({1'b0, slot_new(k)}));
          default: chk(1'b0, "R3 extra transfer", 64'(n), 64'd3);
        endcase
        n++;
      end
      if (psw_load_o) begin
        chk(n == 3, "R3 transfer count", 64'(n), 64'd3);
        chk(psw_o == mkword(slot_new(k)), "R9 loaded PSW", psw_o, mkword(slot_new(k)));
        chk(!busy_o, "R9 R10 busy low at load", 64'(busy_o), 64'd0);
        chk(go_run_o == exp_go, "R11 run strobe", 64'(go_run_o), 64'(exp_go));
        chk(seen_ack, "R1 acknowledge seen", 64'(seen_ack), 64'd1);
        break;
      end
    end
    mem_ready_i = 1'b0;
  endtask

  task automatic run_case(input bit keep, input bit always_ready, input int force_k);
    int k;
    logic [63:0] e_old, e_code;
    k = exp_pick(req_i, run_i);
    if (force_k >= 0) chk(k == force_k, "R1 priority order", 64'(k), 64'(force_k));
    if (k < 0) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(ack_o == 6'b0 && !busy_o && !mem_valid_o, "R2 ignored while stopped",
            64'({ack_o, busy_o, mem_valid_o}), 64'd0);
      end
      req_i = 6'b0;
    end else begin
      e_old  = exp_old(k, ctl_i, ia_i, ilen_i, refetch_i);
      e_code = {48'b0, cause_i[16*k +: 16]};
      service(k, keep, (k == 5) && !run_i, e_old, e_code, always_ready);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", 64'd0, 64'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_i = '0; run_i = 1'b1; mem_ready_i = 1'b0; mem_rdata_i = '0;
    scramble();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && ack_o == 0 && !mem_valid_o && !psw_load_o && !go_run_o && psw_o == 0,
        "R13 reset state", 64'({busy_o, ack_o, mem_valid_o, psw_load_o, go_run_o}), 64'd0);
    chk(psw_o == 64'd0, "R13 reset PSW", psw_o, 64'd0);

    // drain: all six pending, expect index order 0..5
    scramble(); run_i = 1'b1; req_i = 6'b111111;
    for (int k = 0; k < 6; k++) run_case(1'b1, 1'b0, k);

    // stopped CPU, no restart pending: nothing happens (R2)
    @(negedge clk);
    run_i = 1'b0; req_i = 6'b011111; scramble();
    run_case(1'b0, 1'b0, -1);

    // stopped CPU, restart among others: restart and run strobe (R11)
    run_i = 1'b0; req_i = 6'b111111; scramble();
    run_case(1'b0, 1'b1, 5);
    @(negedge clk);

    // running restart alone: no run strobe (R11)
    run_i = 1'b1; req_i = 6'b100000; scramble();
    run_case(1'b0, 1'b0, 5);

    // program re-execution with address wrap (R7)
    @(negedge clk);
    run_i = 1'b1; req_i = 6'b000010; scramble();
    ia_i = 24'h000001; ilen_i = 2'd3; refetch_i = 1'b1;
    run_case(1'b0, 1'b0, 1);

    // supervisor call ignores refetch flag, keeps length code (R6, R7)
    @(negedge clk);
    req_i = 6'b000100; scramble(); ilen_i = 2'd2; refetch_i = 1'b1;
    run_case(1'b0, 1'b1, 2);

    // external with refetch set: ILC zero, address unchanged (R6)
    @(negedge clk);
    req_i = 6'b001000; scramble(); refetch_i = 1'b1;
    run_case(1'b0, 1'b0, 3);

    // random mix
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      scramble();
      req_i = 6'($urandom);
      run_i = ($urandom % 4) != 0;
      run_case(1'b0, 1'b0, -1);
    end

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule